// File: doc/BRIEF.md
# MSI-X Request Validator and Issuer

This block sits between application logic that wants to raise MSI-X interrupts and a downstream packet builder that turns posted memory writes into transaction-layer packets. Application logic presents a request strobe together with a target function number, a 64-bit message address and a 32-bit message data word. The block checks the request against per-function interrupt control state. If it passes, the block hands a write descriptor (address plus data) downstream. If it fails, the request is dropped and an error is reported. Either way, the requester receives exactly one acknowledge.

Two physical functions and a parameterised number of virtual functions share the one request/acknowledge pair. Each function owns an Enable bit and a Function Mask bit. These bits are loaded through a small configuration write port and are reflected on status vectors.

The descriptor output is a valid/ready stream. Once `desc_valid` rises, it stays high and `desc_addr`/`desc_data` hold their values until a cycle in which `desc_ready` is high. That cycle is the transfer. `desc_ready` may be high or low at any time, including while no descriptor is offered. `desc_valid` never depends combinationally on `desc_ready`. The acknowledge for a sent message is combinational from `desc_ready` in the transfer cycle.

Top module: `msix_req_gate`

## Requirements
- R1: While `rst` (synchronous, active high) has been sampled high, every Enable bit reads 0, every Function Mask bit reads 1, and `ack` and `desc_valid` read 0.
- R2: A configuration write (`cfg_we` high, `cfg_fn` < 2+NUM_VF) loads `cfg_enable` and `cfg_mask` into that function's bits, visible on the status outputs from the next cycle. A write with an out-of-range `cfg_fn` changes no bit. Bit i of `en_pf`/`mask_pf` is physical function i. Bit k of `en_vf`/`mask_vf` is virtual function k.
- R3: Function number 0 or 1 selects a physical function. Number 2+k selects virtual function k, for k < NUM_VF. A request with any number ≥ 2+NUM_VF is rejected.
- R4: A request to a function whose Enable bit is 0 is rejected.
- R5: A request to a function whose Function Mask bit is 1 is rejected.
- R6: A rejected request gives `ack`=1 with `err`=1 for exactly one cycle, the cycle after the request was accepted, and never raises `desc_valid`. `err` is meaningful only while `ack` is high and reads 0 otherwise.
- R7: A request that passes every check raises `desc_valid` in the cycle after acceptance. The descriptor carries the address and data sampled in the acceptance cycle and holds them until transferred. `ack`=1 with `err`=0 occurs exactly in the transfer cycle.
- R8: A request is accepted only when nothing is outstanding. A strobe from the acceptance cycle through the acknowledge cycle is ignored, and `ack` is never high in two consecutive cycles.
- R9: The verdict uses the control bits as they stood before any configuration write in the acceptance cycle. A configuration change after acceptance does not alter an outcome already decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fn | input | FN_W | Function number addressed by the configuration write |
| cfg_enable | input | 1 | Enable value to load |
| cfg_mask | input | 1 | Function Mask value to load |
| req_valid | input | 1 | Interrupt request strobe |
| req_fn | input | FN_W | Target function number of the request |
| req_addr | input | ADDR_W | Message address, sampled with the strobe |
| req_data | input | DATA_W | Message data, sampled with the strobe |
| ack | output | 1 | Request finished (one cycle) |
| err | output | 1 | With `ack`: 0 = message sent, 1 = rejected, nothing sent |
| desc_valid | output | 1 | Write descriptor offered downstream |
| desc_ready | input | 1 | Downstream accepts the descriptor |
| desc_addr | output | ADDR_W | Descriptor write address |
| desc_data | output | DATA_W | Descriptor write data |
| en_pf | output | 2 | Enable bits of the physical functions |
| mask_pf | output | 2 | Function Mask bits of the physical functions |
| en_vf | output | NUM_VF | Enable bits of the virtual functions |
| mask_vf | output | NUM_VF | Function Mask bits of the virtual functions |

## Verification
Requests are aimed at each physical function, at the first and last virtual function, and at the first and a far out-of-range function number. This separates the decode of function numbers from the enable and mask checks. Each function is placed in all four enable/mask combinations, so a fault in either bit's polarity or selection shows up as a wrong `err`. Valid requests meet downstream back-pressure of zero to several cycles while a conflicting strobe is held high, which tells a held descriptor from a recaptured one and an ignored strobe from an accepted one. Configuration writes land in the acceptance cycle and while a descriptor is pending, which separates a verdict taken from the old state from one taken from the new state.

// File: rtl/msix_gate_pkg.sv
package msix_gate_pkg;

  localparam int NUM_PF = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_REJ  = 2'd2
  } gate_state_e;

  typedef struct packed {
    logic bad_fn;
    logic disabled;
    logic masked;
  } verdict_t;

endpackage

// File: rtl/msix_fn_ctl.sv
module msix_fn_ctl #(
  parameter int NUM_FN = 6,
  parameter int FN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic              cfg_enable,
  input  logic              cfg_mask,
  output logic [NUM_FN-1:0] en_vec,
  output logic [NUM_FN-1:0] mask_vec
);

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
    logic hit;
    assign hit = cfg_we && (cfg_fn == FN_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_vec[i]   <= 1'b0;
        mask_vec[i] <= 1'b1;
      end else if (hit) begin
        en_vec[i]   <= cfg_enable;
        mask_vec[i] <= cfg_mask;
      end
    end
  end

endmodule

// File: rtl/msix_req_judge.sv
module msix_req_judge
  import msix_gate_pkg::*;
#(
  parameter int NUM_FN = 6,
  parameter int FN_W   = 8
) (
  input  logic [FN_W-1:0]   req_fn,
  input  logic [NUM_FN-1:0] en_vec,
  input  logic [NUM_FN-1:0] mask_vec,
  output logic              reject
);

  verdict_t vd;
  logic     hit_any;
  logic     sel_en;
  logic     sel_mask;

  always_comb begin
    hit_any  = 1'b0;
    sel_en   = 1'b0;
    sel_mask = 1'b1;
    for (int i = 0; i < NUM_FN; i++) begin
      if (req_fn == FN_W'(i)) begin
        hit_any  = 1'b1;
        sel_en   = en_vec[i];
        sel_mask = mask_vec[i];
      end
    end
    vd.bad_fn   = !hit_any;
    vd.disabled = !sel_en;
    vd.masked   = sel_mask;
    reject      = vd.bad_fn | vd.disabled | vd.masked;
  end

endmodule

// File: rtl/msix_issue_ctl.sv
module msix_issue_ctl
  import msix_gate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              reject,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              desc_ready,
  output logic              busy,
  output logic              ack,
  output logic              err,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [DATA_W-1:0] desc_data
);

  gate_state_e state_q;
  logic        accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= reject ? ST_REJ : ST_SEND;
        ST_SEND: if (desc_ready) state_q <= ST_IDLE;
        ST_REJ:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_addr <= '0;
      desc_data <= '0;
    end else if (accept && !reject) begin
      desc_addr <= req_addr;
      desc_data <= req_data;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign desc_valid = (state_q == ST_SEND);
  assign err        = (state_q == ST_REJ);
  assign ack        = err || (desc_valid && desc_ready);

endmodule

// File: rtl/msix_req_gate.sv
module msix_req_gate
  import msix_gate_pkg::*;
#(
  parameter int NUM_VF = 4,
  parameter int FN_W   = 8,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic              cfg_enable,
  input  logic              cfg_mask,
  input  logic              req_valid,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              ack,
  output logic              err,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [DATA_W-1:0] desc_data,
  output logic [NUM_PF-1:0] en_pf,
  output logic [NUM_PF-1:0] mask_pf,
  output logic [NUM_VF-1:0] en_vf,
  output logic [NUM_VF-1:0] mask_vf
);

  localparam int NUM_FN = NUM_PF + NUM_VF;

  logic [NUM_FN-1:0] en_vec;
  logic [NUM_FN-1:0] mask_vec;
  logic              reject;
  logic              busy;

  msix_fn_ctl #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_fn_ctl (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_fn     (cfg_fn),
    .cfg_enable (cfg_enable),
    .cfg_mask   (cfg_mask),
    .en_vec     (en_vec),
    .mask_vec   (mask_vec)
  );

  msix_req_judge #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_judge (
    .req_fn   (req_fn),
    .en_vec   (en_vec),
    .mask_vec (mask_vec),
    .reject   (reject)
  );

  msix_issue_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .reject     (reject),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .desc_ready (desc_ready),
    .busy       (busy),
    .ack        (ack),
    .err        (err),
    .desc_valid (desc_valid),
    .desc_addr  (desc_addr),
    .desc_data  (desc_data)
  );

  assign en_pf   = en_vec[NUM_PF-1:0];
  assign mask_pf = mask_vec[NUM_PF-1:0];
  assign en_vf   = en_vec[NUM_FN-1:NUM_PF];
  assign mask_vf = mask_vec[NUM_FN-1:NUM_PF];

endmodule

// File: rtl/msix_req_gate_chk.sv
module msix_req_gate_chk #(
  parameter int NUM_VF = 4,
  parameter int FN_W   = 8,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [FN_W-1:0]   cfg_fn,
  input logic              cfg_enable,
  input logic              cfg_mask,
  input logic              req_valid,
  input logic [FN_W-1:0]   req_fn,
  input logic              busy,
  input logic              ack,
  input logic              err,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [DATA_W-1:0] desc_data,
  input logic [1:0]        en_pf,
  input logic [1:0]        mask_pf,
  input logic [NUM_VF-1:0] en_vf,
  input logic [NUM_VF-1:0] mask_vf
);

  localparam int NUM_FN = 2 + NUM_VF;

  logic [NUM_FN-1:0] en_all;
  logic [NUM_FN-1:0] mask_all;
  logic              in_rng;
  logic              t_en;
  logic              t_mask;
  logic              taken;

  assign en_all   = {en_vf, en_pf};
  assign mask_all = {mask_vf, mask_pf};
  assign taken    = req_valid && !busy;

  always_comb begin
    in_rng = 1'b0;
    t_en   = 1'b0;
    t_mask = 1'b1;
    for (int i = 0; i < NUM_FN; i++) begin
      if (req_fn == FN_W'(i)) begin
        in_rng = 1'b1;
        t_en   = en_all[i];
        t_mask = mask_all[i];
      end
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (en_all == '0) && (mask_all == '1) && !ack && !desc_valid);

  // R2
  for (genvar i = 0; i < NUM_FN; i++) begin : g_cfg
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_fn == FN_W'(i)) |=>
        (en_all[i] == $past(cfg_enable)) && (mask_all[i] == $past(cfg_mask)));
  end

  a_r2_cfg_invalid: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we || !(cfg_fn < FN_W'(NUM_FN))) |=>
      $stable(en_all) && $stable(mask_all));

  // R3
  a_r3_bad_fn: assert property (@(posedge clk) disable iff (rst)
    (taken && !in_rng) |=> ack && err && !desc_valid);

  // R4
  a_r4_disabled: assert property (@(posedge clk) disable iff (rst)
    (taken && in_rng && !t_en) |=> ack && err && !desc_valid);

  // R5
  a_r5_masked: assert property (@(posedge clk) disable iff (rst)
    (taken && in_rng && t_mask) |=> ack && err && !desc_valid);

  // R6
  a_r6_err_qualified: assert property (@(posedge clk) disable iff (rst)
    err |-> ack && !desc_valid);

  // R7
  a_r7_pass_offers: assert property (@(posedge clk) disable iff (rst)
    (taken && in_rng && t_en && !t_mask) |=> desc_valid && !err);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready) |=>
      desc_valid && $stable(desc_addr) && $stable(desc_data));

  a_r7_ack_on_xfer: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_ready) |-> ack && !err);

  // R8
  a_r8_single_ack: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

bind msix_req_gate msix_req_gate_chk #(
  .NUM_VF (NUM_VF),
  .FN_W   (FN_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_fn     (cfg_fn),
  .cfg_enable (cfg_enable),
  .cfg_mask   (cfg_mask),
  .req_valid  (req_valid),
  .req_fn     (req_fn),
  .busy       (busy),
  .ack        (ack),
  .err        (err),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_addr  (desc_addr),
  .desc_data  (desc_data),
  .en_pf      (en_pf),
  .mask_pf    (mask_pf),
  .en_vf      (en_vf),
  .mask_vf    (mask_vf)
);

// File: tb/msix_req_gate_test.sv
module msix_req_gate_test;

  localparam int NUM_VF = 4;
  localparam int FN_W   = 8;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 32;
  localparam int NUM_FN = 2 + NUM_VF;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [FN_W-1:0]   cfg_fn;
  logic              cfg_enable;
  logic              cfg_mask;
  logic              req_valid;
  logic [FN_W-1:0]   req_fn;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              ack;
  logic              err;
  logic              desc_valid;
  logic              desc_ready;
  logic [ADDR_W-1:0] desc_addr;
  logic [DATA_W-1:0] desc_data;
  logic [1:0]        en_pf;
  logic [1:0]        mask_pf;
  logic [NUM_VF-1:0] en_vf;
  logic [NUM_VF-1:0] mask_vf;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  logic [NUM_FN-1:0] en_m;
  logic [NUM_FN-1:0] mask_m;

  always #2.5 clk = ~clk;

  msix_req_gate #(
    .NUM_VF (NUM_VF), .FN_W (FN_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) uut (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_fn (cfg_fn), .cfg_enable (cfg_enable), .cfg_mask (cfg_mask),
    .req_valid (req_valid), .req_fn (req_fn), .req_addr (req_addr), .req_data (req_data),
    .ack (ack), .err (err),
    .desc_valid (desc_valid), .desc_ready (desc_ready),
    .desc_addr (desc_addr), .desc_data (desc_data),
    .en_pf (en_pf), .mask_pf (mask_pf), .en_vf (en_vf), .mask_vf (mask_vf)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expect_pass(input int fn);
    if (fn >= NUM_FN) return 1'b0;
    return en_m[fn] && !mask_m[fn];
  endfunction

  function automatic string reject_tag(input int fn);
    if (fn >= NUM_FN) return "R3 bad function";
    if (!en_m[fn]) return "R4 disabled";
    return "R5 masked";
  endfunction

  task automatic chk_status(input string tag);
    chk({en_vf, en_pf} === en_m && {mask_vf, mask_pf} === mask_m, tag,
        {mask_vf, mask_pf, en_vf, en_pf}, {mask_m, en_m});
  endtask

  task automatic cfg_write(input int fn, input logic e, input logic m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fn = FN_W'(fn); cfg_enable = e; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    if (fn < NUM_FN) begin
      en_m[fn] = e; mask_m[fn] = m;
    end
    chk_status("R2 status after config write");
  endtask

  // Drives one request, holds a conflicting strobe while busy, checks outcome.
  task automatic do_req(input int fn, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int delay);
    bit pass;
    pass = expect_pass(fn);
    @(negedge clk);
    req_valid = 1'b1; req_fn = FN_W'(fn); req_addr = a; req_data = d;
    @(negedge clk);
    req_fn = 8'd0; req_addr = ~a; req_data = ~d;
    if (!pass) begin
      chk(ack === 1'b1 && err === 1'b1 && desc_valid === 1'b0,
          {reject_tag(fn), " / R6 reject ack"}, {ack, err, desc_valid}, 3'b110);
      @(negedge clk);
      req_valid = 1'b0;
      chk(ack === 1'b0 && err === 1'b0 && desc_valid === 1'b0,
          "R6/R8 single reject ack, strobe ignored", {ack, err, desc_valid}, 3'b000);
    end else begin
      for (int k = 0; k < delay; k++) begin
        chk(desc_valid === 1'b1 && ack === 1'b0 && desc_addr === a && desc_data === d,
            "R7/R8 descriptor held under back-pressure",
            {desc_valid, ack, desc_data, desc_addr}, {2'b10, d, a});
        @(negedge clk);
      end
      desc_ready = 1'b1;
      #1;
      chk(desc_valid === 1'b1 && ack === 1'b1 && err === 1'b0 &&
          desc_addr === a && desc_data === d,
          "R7 transfer with ack err=0",
          {desc_valid, ack, err, desc_data, desc_addr}, {3'b110, d, a});
      @(negedge clk);
      desc_ready = 1'b0;
      req_valid  = 1'b0;
      chk(ack === 1'b0 && desc_valid === 1'b0,
          "R8 no second ack, strobe while busy ignored", {ack, desc_valid}, 2'b00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; cfg_we = 1'b0; cfg_fn = '0; cfg_enable = 1'b0; cfg_mask = 1'b0;
    req_valid = 1'b0; req_fn = '0; req_addr = '0; req_data = '0; desc_ready = 1'b0;
    en_m = '0; mask_m = '1;
    repeat (3) @(negedge clk);
    chk(ack === 1'b0 && desc_valid === 1'b0, "R1 reset outputs", {ack, desc_valid}, 2'b00);
    chk_status("R1 reset status");
    rst = 1'b0;

    // R1/R5: after reset everything is disabled and masked
    do_req(0, 64'h1111_2222_3333_4444, 32'hAAAA_0001, 0);

    // R4: enabled=0 mask=0 still rejected; R5: enabled=1 mask=1 rejected
    cfg_write(1, 1'b0, 1'b0);
    do_req(1, 64'h10, 32'h1, 0);
    cfg_write(1, 1'b1, 1'b1);
    do_req(1, 64'h20, 32'h2, 0);

    // R3: PFs, first and last VF, first and far invalid numbers
    cfg_write(0, 1'b1, 1'b0);
    cfg_write(1, 1'b1, 1'b0);
    cfg_write(2, 1'b1, 1'b0);
    cfg_write(NUM_FN - 1, 1'b1, 1'b0);
    do_req(0, 64'hDEAD_BEEF_0000_0100, 32'h0000_0100, 0);
    do_req(1, 64'hDEAD_BEEF_0000_0200, 32'h0000_0200, 1);
    do_req(2, 64'hDEAD_BEEF_0000_0300, 32'h0000_0300, 2);
    do_req(NUM_FN - 1, 64'hDEAD_BEEF_0000_0400, 32'h0000_0400, 3);
    do_req(NUM_FN, 64'h500, 32'h500, 0);
    do_req(255, 64'h600, 32'h600, 0);

    // R2: write to an out-of-range function leaves all bits unchanged
    cfg_write(NUM_FN, 1'b0, 1'b1);
    cfg_write(200, 1'b0, 1'b1);

    // R9: config write in the acceptance cycle does not affect the verdict
    cfg_write(3, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_fn = 8'd3; req_addr = 64'h77; req_data = 32'h77;
    cfg_we = 1'b1; cfg_fn = 8'd3; cfg_enable = 1'b1; cfg_mask = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    en_m[3] = 1'b1; mask_m[3] = 1'b0;
    chk(ack === 1'b1 && err === 1'b1, "R9 verdict uses old state (reject)",
        {ack, err}, 2'b11);
    @(negedge clk);
    chk_status("R9 config write in acceptance cycle still applied");

    // R9: disabling the function while a descriptor is pending does not abort it
    @(negedge clk);
    req_valid = 1'b1; req_fn = 8'd3; req_addr = 64'h88; req_data = 32'h88;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_fn = 8'd3; cfg_enable = 1'b0; cfg_mask = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    en_m[3] = 1'b0; mask_m[3] = 1'b1;
    chk(desc_valid === 1'b1 && desc_addr === 64'h88, "R9 pending descriptor survives",
        {desc_valid, desc_addr}, {1'b1, 64'h88});
    desc_ready = 1'b1;
    #1;
    chk(ack === 1'b1 && err === 1'b0, "R9 pending request acked err=0", {ack, err}, 2'b10);
    @(negedge clk);
    desc_ready = 1'b0;

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      int fn;
      sel = int'($urandom_range(0, 9));
      fn  = ($urandom_range(0, 15) == 0) ? int'($urandom_range(NUM_FN, 255))
                                          : int'($urandom_range(0, NUM_FN - 1));
      if (sel < 3) begin
        cfg_write(fn, $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
      end else begin
        do_req(fn, {$urandom(), $urandom()}, $urandom(), int'($urandom_range(0, 3)));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule